// File: doc/BRIEF.md
# Thread Interrupt Priority Context

This block holds the interrupt priority state of one hardware thread, split into four rings: user (ring 0), OS (ring 1), pool (ring 2) and physical (ring 3). Each ring keeps a one-hot-per-level pending buffer and a current processor priority. The ring's pending priority is derived from its buffer and is always current. Its notification source flag is also derived and is always current.

A notification names a ring and a priority. A priority in the active range sets one bit in that ring's pending buffer. A ring signals an exception whenever its most favoured pending level is numerically lower than its current priority. The pool and physical rings drive the hypervisor exception line. The OS ring drives the OS exception line.

Software reaches the context through four pages. Each page is a window of 64 byte addresses: 16 bytes for each ring. The page number sets how many rings are visible. Reads are answered by a two-state access machine:
- `ACC_IDLE` is the state with no response pending.
- `ACC_RESP` is the state that presents read data for one cycle.
- The machine moves from `ACC_IDLE` to `ACC_RESP` on any read request.
- It stays in `ACC_RESP` on a back-to-back read.
- It returns to `ACC_IDLE` in a cycle with no read.

Top module: `tctx_top`

## Requirements
- R1: After reset, every pending buffer is 0x00 and every pending priority reads 0xFF. Every current priority is 0x00. Both exception lines are low and `acc_rvalid` is low.
- R2: A notification with priority p in 0..7 ORs the value 1 << (7 - p) into the pending buffer of the ring given by `ntf_ring`, so priority 0 sets bit 7. Other bits and other rings are unchanged. Within a ring, the byte offsets are 0 for the notification source flag, 1 for the current priority, 2 for the pending buffer and 3 for the pending priority.
- R3: A notification with a priority above 7, including 0xFF, changes no state.
- R4: The pending priority reads as the index p of the most favoured set level, meaning the highest set buffer bit, at bit 7 - p. It reads 0xFF when the buffer is empty.
- R5: A ring's exception condition is true when its pending priority is numerically below its current priority. Bit 7 of the ring's notification source byte shows the condition. `os_excp` follows ring 1. `hv_excp` is the OR of rings 2 and 3. Ring 0 drives no line.
- R6: A write to the current priority byte takes effect at the clock edge. The exception lines reflect the new value in the cycle that follows that edge.
- R7: A write to the pending buffer byte replaces its contents. A notification to the same ring in the same cycle is ORed on top of the written value.
- R8: The access address is formed as follows: `acc_off[5:4]` selects the ring and `acc_off[3:0]` selects the byte. Page q (0 hardware, 1 hypervisor, 2 OS, 3 user) sees ring r only when r + q <= 3. Reads of a hidden ring return 0x00, and writes to a hidden ring are dropped.
- R9: Read data appears on `acc_rdata` with `acc_rvalid` high in the cycle after `acc_rd`. `acc_rvalid` is high for one cycle for each read. Bytes 4 to 15 of a ring read 0x00. Writes to the notification source byte and the pending priority byte are ignored.
- R10: A read request in either state moves the access machine to `ACC_RESP`. A cycle without a read returns it to `ACC_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_valid | input | 1 | Notification strobe |
| ntf_ring | input | 2 | Target ring of the notification |
| ntf_prio | input | 8 | Priority of the notification |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| acc_page | input | 2 | Access page (privilege view) |
| acc_off | input | 6 | Ring and byte offset in the page |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data |
| acc_rvalid | output | 1 | Read data valid |
| hv_excp | output | 1 | Hypervisor exception line |
| os_excp | output | 1 | OS exception line |

## Verification
The bench builds the block with its default of eight active priority levels. At this width the priority-to-bit mapping reaches both ends of the pending buffer: priority 0 at bit 7 and priority 7 at bit 0. Out-of-range priorities are also exercised with a mid value (0x20) and with 0xFF. All four pages are driven against rings inside and outside their view, so every visibility boundary of r + q <= 3 is exercised. The pending buffer is written and notified in the same cycle, and reads are issued back to back.

// File: rtl/tctx_pkg.sv
package tctx_pkg;

    localparam int RING_CNT   = 4;
    localparam int RING_IDX_W = $clog2(RING_CNT);
    localparam int BYTE_W     = 8;
    localparam int SLOT_W     = 4;
    localparam int PAGE_W     = 2;

    localparam logic [SLOT_W-1:0] SLOT_NSR  = 4'd0;
    localparam logic [SLOT_W-1:0] SLOT_CPPR = 4'd1;
    localparam logic [SLOT_W-1:0] SLOT_IPB  = 4'd2;
    localparam logic [SLOT_W-1:0] SLOT_PIPR = 4'd3;

    localparam logic [BYTE_W-1:0] PRIO_NONE = 8'hFF;

    typedef enum logic [RING_IDX_W-1:0] {
        RING_USER = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2,
        RING_PHYS = 2'd3
    } ring_e;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] nsr;
        logic [BYTE_W-1:0] cppr;
        logic [BYTE_W-1:0] ipb;
        logic [BYTE_W-1:0] pipr;
    } ring_view_t;

endpackage

// File: rtl/tctx_ring.sv
module tctx_ring
    import tctx_pkg::*;
#(
    parameter int LEVELS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ntf_hit,
    input  logic [BYTE_W-1:0] ntf_prio,
    input  logic              ipb_we,
    input  logic              cppr_we,
    input  logic [BYTE_W-1:0] wdata,
    output ring_view_t        view,
    output logic              excp
);

    logic [LEVELS-1:0] ipb_q;
    logic [LEVELS-1:0] ntf_mask;
    logic [LEVELS-1:0] ipb_base;
    logic [BYTE_W-1:0] cppr_q;
    logic [BYTE_W-1:0] pipr;

    // one-hot level mask; out-of-range priorities produce no bit
    always_comb begin
        ntf_mask = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (ntf_hit && ntf_prio == BYTE_W'(i)) begin
                ntf_mask[LEVELS-1-i] = 1'b1;
            end
        end
    end

    assign ipb_base = ipb_we ? wdata[LEVELS-1:0] : ipb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipb_q  <= '0;
            cppr_q <= '0;
        end else begin
            ipb_q <= ipb_base | ntf_mask;
            if (cppr_we) begin
                cppr_q <= wdata;
            end
        end
    end

    // most favoured pending level: scan from the top bit down
    always_comb begin
        logic found;
        found = 1'b0;
        pipr  = PRIO_NONE;
        for (int i = 0; i < LEVELS; i++) begin
            if (ipb_q[LEVELS-1-i] && !found) begin
                pipr  = BYTE_W'(i);
                found = 1'b1;
            end
        end
    end

    assign excp      = (pipr < cppr_q);
    assign view.nsr  = {excp, {(BYTE_W-1){1'b0}}};
    assign view.cppr = cppr_q;
    assign view.ipb  = BYTE_W'(ipb_q);
    assign view.pipr = pipr;

endmodule

// File: rtl/tctx_access.sv
module tctx_access
    import tctx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_rd,
    input  logic                  acc_wr,
    input  logic [PAGE_W-1:0]     acc_page,
    input  logic [5:0]            acc_off,
    input  ring_view_t            views [RING_CNT],
    output logic [RING_CNT-1:0]   ipb_we,
    output logic [RING_CNT-1:0]   cppr_we,
    output logic [BYTE_W-1:0]     rdata,
    output logic                  rvalid
);

    localparam int SUM_W = RING_IDX_W + 1;

    acc_state_e              state_q, state_d;
    logic [RING_IDX_W-1:0]   ring_sel;
    logic [SLOT_W-1:0]       slot;
    logic                    visible;
    logic [BYTE_W-1:0]       rd_byte;
    logic [BYTE_W-1:0]       rdata_q;

    assign ring_sel = acc_off[5:4];
    assign slot     = acc_off[3:0];
    // lower page numbers are more privileged and see more rings
    assign visible  = (SUM_W'(ring_sel) + SUM_W'(acc_page)) <= SUM_W'(RING_CNT - 1);

    for (genvar r = 0; r < RING_CNT; r++) begin : g_we
        assign ipb_we[r]  = acc_wr && visible && (ring_sel == RING_IDX_W'(r)) && (slot == SLOT_IPB);
        assign cppr_we[r] = acc_wr && visible && (ring_sel == RING_IDX_W'(r)) && (slot == SLOT_CPPR);
    end

    always_comb begin
        rd_byte = '0;
        if (visible) begin
            case (slot)
                SLOT_NSR:  rd_byte = views[ring_sel].nsr;
                SLOT_CPPR: rd_byte = views[ring_sel].cppr;
                SLOT_IPB:  rd_byte = views[ring_sel].ipb;
                SLOT_PIPR: rd_byte = views[ring_sel].pipr;
                default:   rd_byte = '0;
            endcase
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: state_d = acc_rd ? ACC_RESP : ACC_IDLE;
            ACC_RESP: state_d = acc_rd ? ACC_RESP : ACC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (acc_rd) begin
            rdata_q <= rd_byte;
        end
    end

    assign rvalid = (state_q == ACC_RESP);
    assign rdata  = rvalid ? rdata_q : '0;

endmodule

// File: rtl/tctx_top.sv
module tctx_top
    import tctx_pkg::*;
#(
    parameter int LEVELS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ntf_valid,
    input  logic [1:0] ntf_ring,
    input  logic [7:0] ntf_prio,
    input  logic       acc_rd,
    input  logic       acc_wr,
    input  logic [1:0] acc_page,
    input  logic [5:0] acc_off,
    input  logic [7:0] acc_wdata,
    output logic [7:0] acc_rdata,
    output logic       acc_rvalid,
    output logic       hv_excp,
    output logic       os_excp
);

    ring_view_t            views [RING_CNT];
    logic [RING_CNT-1:0]   ring_excp;
    logic [RING_CNT-1:0]   ipb_we;
    logic [RING_CNT-1:0]   cppr_we;

    for (genvar r = 0; r < RING_CNT; r++) begin : g_ring
        tctx_ring #(.LEVELS(LEVELS)) ring_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .ntf_hit  (ntf_valid && (ntf_ring == RING_IDX_W'(r))),
            .ntf_prio (ntf_prio),
            .ipb_we   (ipb_we[r]),
            .cppr_we  (cppr_we[r]),
            .wdata    (acc_wdata),
            .view     (views[r]),
            .excp     (ring_excp[r])
        );
    end

    tctx_access access_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .acc_page (acc_page),
        .acc_off  (acc_off),
        .views    (views),
        .ipb_we   (ipb_we),
        .cppr_we  (cppr_we),
        .rdata    (acc_rdata),
        .rvalid   (acc_rvalid)
    );

    assign os_excp = ring_excp[RING_OS];
    assign hv_excp = ring_excp[RING_POOL] | ring_excp[RING_PHYS];

endmodule

// File: rtl/tctx_checker.sv
module tctx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ntf_valid,
    input logic [7:0] ntf_prio,
    input logic       acc_rd,
    input logic       acc_wr,
    input logic [1:0] acc_page,
    input logic [5:0] acc_off,
    input logic       acc_rvalid,
    input logic       hv_excp,
    input logic       os_excp
);

    // R9 / R10: a read is answered in the following cycle
    a_r9_rvalid_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> acc_rvalid);

    // R10: no read means the machine returns to idle
    a_r10_idle_without_rd: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> !acc_rvalid);

    // R3: an out-of-range notification leaves the lines steady
    a_r3_bad_prio_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid && ntf_prio > 8'd7 && !acc_wr) |=> ($stable(hv_excp) && $stable(os_excp)));

    // R5: without a write, notifications can only raise a line
    a_r5_os_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> !$fell(os_excp));

    a_r5_hv_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> !$fell(hv_excp));

    // R8: the user page cannot touch rings other than ring 0
    a_r8_user_page_wr_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_page == 2'd3 && acc_off[5:4] != 2'd0 && !ntf_valid)
        |=> ($stable(hv_excp) && $stable(os_excp)));

endmodule

bind tctx_top tctx_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ntf_valid  (ntf_valid),
    .ntf_prio   (ntf_prio),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .acc_page   (acc_page),
    .acc_off    (acc_off),
    .acc_rvalid (acc_rvalid),
    .hv_excp    (hv_excp),
    .os_excp    (os_excp)
);

// File: tb/tctx_top_tb_top.sv
`timescale 1ns/1ps
module tctx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ntf_valid = 1'b0;
    logic [1:0] ntf_ring = '0;
    logic [7:0] ntf_prio = '0;
    logic       acc_rd = 1'b0;
    logic       acc_wr = 1'b0;
    logic [1:0] acc_page = '0;
    logic [5:0] acc_off = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       acc_rvalid;
    logic       hv_excp;
    logic       os_excp;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tctx_top dut_i (
        .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_ring(ntf_ring),
        .ntf_prio(ntf_prio), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_page(acc_page),
        .acc_off(acc_off), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_rvalid(acc_rvalid), .hv_excp(hv_excp), .os_excp(os_excp)
    );

    // fields: req[31:28] kind[27:26] page[25:24] off[23:18] data[17:10] exp[9:2] lines{hv,os}[1:0]
    // kind 0 notify (ring = off[5:4]), 1 write, 2 read
    localparam int NV = 31;
    localparam logic [31:0] VEC [0:NV-1] = '{
        {4'd1, 2'd2, 2'd0, 6'h22, 8'h00, 8'h00, 2'b00}, // R1 empty buffer
        {4'd1, 2'd2, 2'd0, 6'h23, 8'h00, 8'hFF, 2'b00}, // R1 none pending
        {4'd6, 2'd1, 2'd0, 6'h11, 8'h05, 8'h00, 2'b00}, // R6 OS cppr 5
        {4'd2, 2'd0, 2'd0, 6'h10, 8'h06, 8'h00, 2'b00}, // R2 prio 6
        {4'd2, 2'd2, 2'd0, 6'h12, 8'h00, 8'h02, 2'b00}, // R2 bit 1
        {4'd4, 2'd2, 2'd0, 6'h13, 8'h00, 8'h06, 2'b00}, // R4
        {4'd5, 2'd0, 2'd0, 6'h10, 8'h03, 8'h00, 2'b01}, // R5 3 < 5
        {4'd5, 2'd2, 2'd2, 6'h10, 8'h00, 8'h80, 2'b01}, // R5 nsr flag
        {4'd4, 2'd2, 2'd2, 6'h13, 8'h00, 8'h03, 2'b01}, // R4 favoured
        {4'd6, 2'd1, 2'd2, 6'h11, 8'h02, 8'h00, 2'b00}, // R6 line drops
        {4'd3, 2'd0, 2'd0, 6'h10, 8'h20, 8'h00, 2'b00}, // R3 prio 0x20
        {4'd3, 2'd2, 2'd0, 6'h12, 8'h00, 8'h12, 2'b00}, // R3
        {4'd3, 2'd0, 2'd0, 6'h10, 8'hFF, 8'h00, 2'b00}, // R3 prio 0xFF
        {4'd3, 2'd2, 2'd0, 6'h13, 8'h00, 8'h03, 2'b00}, // R3
        {4'd8, 2'd1, 2'd3, 6'h11, 8'hFF, 8'h00, 2'b00}, // R8 hidden write
        {4'd8, 2'd2, 2'd0, 6'h11, 8'h00, 8'h02, 2'b00}, // R8 unchanged
        {4'd8, 2'd2, 2'd3, 6'h11, 8'h00, 8'h00, 2'b00}, // R8 hidden read
        {4'd8, 2'd1, 2'd1, 6'h31, 8'hFF, 8'h00, 2'b00}, // R8 hv page, phys
        {4'd8, 2'd2, 2'd0, 6'h31, 8'h00, 8'h00, 2'b00}, // R8 unchanged
        {4'd6, 2'd1, 2'd0, 6'h31, 8'hFF, 8'h00, 2'b00}, // R6 phys cppr
        {4'd5, 2'd0, 2'd0, 6'h30, 8'h07, 8'h00, 2'b10}, // R5 hv line
        {4'd8, 2'd2, 2'd1, 6'h23, 8'h00, 8'hFF, 2'b10}, // R8 pool visible
        {4'd7, 2'd1, 2'd0, 6'h32, 8'h00, 8'h00, 2'b00}, // R7 clear buffer
        {4'd8, 2'd1, 2'd1, 6'h21, 8'h08, 8'h00, 2'b00}, // R8 pool cppr
        {4'd5, 2'd0, 2'd0, 6'h20, 8'h07, 8'h00, 2'b10}, // R5 pool line
        {4'd9, 2'd2, 2'd0, 6'h04, 8'h00, 8'h00, 2'b10}, // R9 spare byte
        {4'd9, 2'd1, 2'd0, 6'h23, 8'h00, 8'h00, 2'b10}, // R9 pipr write
        {4'd9, 2'd2, 2'd0, 6'h23, 8'h00, 8'h07, 2'b10}, // R9 unchanged
        {4'd5, 2'd0, 2'd0, 6'h00, 8'h00, 8'h00, 2'b10}, // R5 user ring
        {4'd8, 2'd2, 2'd3, 6'h02, 8'h00, 8'h80, 2'b10}, // R8 user view
        {4'd5, 2'd2, 2'd0, 6'h00, 8'h00, 8'h00, 2'b10}  // R5 no flag
    };

    task automatic check(input int req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic idle_inputs();
        ntf_valid = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0;
    endtask

    // drive one operation for one cycle, sample at the following negedge
    task automatic do_op(input logic [1:0] kind, input logic [1:0] page,
                         input logic [5:0] off, input logic [7:0] data);
        @(negedge clk);
        acc_page = page; acc_off = off; acc_wdata = data;
        ntf_ring = off[5:4]; ntf_prio = data;
        ntf_valid = (kind == 2'd0);
        acc_wr    = (kind == 2'd1);
        acc_rd    = (kind == 2'd2);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic read_chk(input int req, input logic [1:0] page, input logic [5:0] off,
                            input logic [7:0] exp);
        do_op(2'd2, page, off, 8'h00);
        check(req, "rvalid", {7'b0, acc_rvalid}, 8'h01);
        check(req, "rdata", acc_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check(1, "hv_excp", {7'b0, hv_excp}, 8'h00);
        check(1, "os_excp", {7'b0, os_excp}, 8'h00);
        check(1, "rvalid", {7'b0, acc_rvalid}, 8'h00);
        read_chk(1, 2'd0, 6'h31, 8'h00);
        read_chk(1, 2'd0, 6'h03, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            do_op(v[27:26], v[25:24], v[23:18], v[17:10]);
            if (v[27:26] == 2'd2) begin
                check(int'(v[31:28]), "rvalid", {7'b0, acc_rvalid}, 8'h01);
                check(int'(v[31:28]), "rdata", acc_rdata, v[9:2]);
            end
            check(int'(v[31:28]), "lines", {6'b0, hv_excp, os_excp}, {6'b0, v[1:0]});
        end

        // R7: write of the buffer and notification in the same cycle
        @(negedge clk);
        acc_wr = 1'b1; acc_page = 2'd0; acc_off = 6'h22; acc_wdata = 8'h00;
        ntf_valid = 1'b1; ntf_ring = 2'd2; ntf_prio = 8'd1;
        @(negedge clk);
        idle_inputs();
        check(7, "hv after merge", {7'b0, hv_excp}, 8'h01);
        read_chk(7, 2'd0, 6'h22, 8'h40);
        read_chk(7, 2'd0, 6'h23, 8'h01);

        // R9 / R10: back-to-back reads, then a single-cycle pulse
        @(negedge clk);
        acc_rd = 1'b1; acc_page = 2'd1; acc_off = 6'h22;
        @(negedge clk);
        check(10, "rvalid first", {7'b0, acc_rvalid}, 8'h01);
        check(10, "rdata first", acc_rdata, 8'h40);
        acc_off = 6'h21;
        @(negedge clk);
        idle_inputs();
        check(10, "rvalid second", {7'b0, acc_rvalid}, 8'h01);
        check(10, "rdata second", acc_rdata, 8'h08);
        @(negedge clk);
        check(9, "rvalid drops", {7'b0, acc_rvalid}, 8'h00);

        // R1: reset in mid-run clears the context
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "lines after reset", {6'b0, hv_excp, os_excp}, 8'h00);
        read_chk(1, 2'd0, 6'h22, 8'h00);
        read_chk(1, 2'd0, 6'h21, 8'h00);
        read_chk(1, 2'd0, 6'h13, 8'hFF);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule